// File: doc/BRIEF.md
# Playback Status Pin Driver

This block drives three general-purpose status pins while a voice player runs and just after it stops. It forms four internal status signals. The first is a registered busy level. The second is a positive end-of-group pulse whose width is a count of sample ticks. The last two are a pair of complementary flash signals that swap at a tick-scaled interval. A two-bit map code, chosen per voice group, places these signals onto the pins in one of four fixed arrangements. One arrangement drives a pin with the inverse of busy.

The player sources a busy flag, a one-cycle pulse when a group finishes, a stop-enable bit for that group, and the sample-rate tick. The block has two small state machines. The pulse sequencer has the states STOP_IDLE and STOP_PULSE. It moves from STOP_IDLE to STOP_PULSE when a group ends with stop enabled. It returns to STOP_IDLE once the width count has expired, or at once when busy rises again (a new trigger). The flash sequencer has the states FLASH_DARK, FLASH_FIRST and FLASH_SECOND. It moves from FLASH_DARK to FLASH_FIRST when busy is seen. It swaps between FLASH_FIRST and FLASH_SECOND each time a half-period of ticks has elapsed. It drops back to FLASH_DARK whenever busy is low, and this clears its count. The pin multiplexer is combinational over these registered signals.

At the default settings the pulse lasts 384 ticks and each flash phase lasts 1500 ticks. With a 6 kHz tick, that is a stop pulse of about 64 ms and a flash rate of 2 Hz.

Top module: `play_status_pins`

## Requirements
- R1: While reset is held, busy, stop and both flash signals are low. With map code 3, OUT3 (the inverted busy) therefore reads high and the other two pins read low.
- R2: The busy signal on a pin follows `busy_in` exactly one clock later, whether or not a tick is present.
- R3: Map code 0 drives OUT1 with the second flash signal, OUT2 with the first flash signal and OUT3 with busy.
- R4: Map code 1 drives OUT1 with stop, OUT2 with the first flash signal and OUT3 with the second flash signal.
- R5: Map code 2 drives OUT1 with the first flash signal, OUT2 with busy and OUT3 with stop.
- R6: Map code 3 drives OUT1 with the first flash signal, OUT2 with busy and OUT3 with the inverse of busy.
- R7: While busy is high the two flash signals are complementary. The first flash signal is high from the clock after busy rises. The two swap after every HALF_TICKS ticks that arrive while flashing.
- R8: While busy is low both flash signals are low and the tick count is cleared. Each new busy period therefore starts with the first flash signal high for a full HALF_TICKS ticks.
- R9: A `group_end` pulse with `stop_en` high raises stop on the next clock. Stop stays high until STOP_TICKS ticks have arrived after that clock.
- R10: A `group_end` pulse with `stop_en` low produces no stop pulse.
- R11: A rising edge of `busy_in` during a stop pulse ends the pulse on the next clock.
- R12: A `group_end` pulse with `stop_en` high during a stop pulse restarts the width count, giving a further full STOP_TICKS ticks.
- R13: Clocks without a tick advance neither the stop width count nor the flash phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_in | input | 1 | High while a group is playing |
| group_end | input | 1 | One-cycle pulse when a group finishes |
| tick | input | 1 | One-cycle sample-rate tick |
| map_sel | input | 2 | Pin arrangement code, 0 to 3 |
| stop_en | input | 1 | Allows a stop pulse for the ending group |
| out1 | output | 1 | Status pin 1 |
| out2 | output | 1 | Status pin 2 |
| out3 | output | 1 | Status pin 3 |

## Verification
Three situations are hard to reach from the pins: an abort while a pulse is running, a restart of a pulse, and a flash restart from a phase that is not aligned. The stimulus first runs the flash sequencer through many ticks, with some cycles left tick-free. This parks its count partway into a phase before busy drops, so a correct clear can be told apart from a carried-over count. For the stop pulse, the bench starts a pulse and lets a few ticks pass. It then either raises busy or repeats the group end. The expected width or abort cycle comes from a tick counter in the bench that is reset at those points.

// File: rtl/play_status_pkg.sv
package play_status_pkg;

    typedef enum logic [1:0] {
        MAP_F2_F1_BUSY   = 2'd0,
        MAP_STOP_F1_F2   = 2'd1,
        MAP_F1_BUSY_STOP = 2'd2,
        MAP_F1_BUSY_NBSY = 2'd3
    } pin_map_e;

    typedef enum logic {
        STOP_IDLE,
        STOP_PULSE
    } stop_state_e;

    typedef enum logic [1:0] {
        FLASH_DARK,
        FLASH_FIRST,
        FLASH_SECOND
    } flash_state_e;

    typedef struct packed {
        logic busy;
        logic stop;
        logic flash1;
        logic flash2;
    } status_sig_t;

endpackage

// File: rtl/stop_pulse_seq.sv
module stop_pulse_seq
    import play_status_pkg::*;
#(
    parameter int STOP_TICKS = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic group_end,
    input  logic stop_en,
    input  logic restart,
    input  logic tick,
    output logic stop_o
);

    localparam int CW = $clog2(STOP_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STOP_TICKS - 1);

    stop_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= STOP_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            STOP_IDLE: begin
                if (group_end && stop_en && !restart) begin
                    state_nx = STOP_PULSE;
                    cnt_nx   = '0;
                end
            end
            STOP_PULSE: begin
                if (restart) begin
                    state_nx = STOP_IDLE;
                    cnt_nx   = '0;
                end else if (group_end && stop_en) begin
                    cnt_nx = '0;
                end else if (tick) begin
                    if (cnt == LAST) begin
                        state_nx = STOP_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: begin
                state_nx = STOP_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        stop_o = (state == STOP_PULSE);
    end

    assert_abort_on_trigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !stop_o);
    assert_no_pulse_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_o && group_end && !stop_en) |=> !stop_o);
    assert_hold_without_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !tick && !restart) |=> stop_o);
    assert_count_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (cnt <= LAST));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import play_status_pkg::*;
#(
    parameter int HALF_TICKS = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic flash1,
    output logic flash2
);

    localparam int CW = $clog2(HALF_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    flash_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLASH_DARK;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FLASH_DARK: begin
                cnt_nx = '0;
                if (active) state_nx = FLASH_FIRST;
            end
            FLASH_FIRST, FLASH_SECOND: begin
                if (!active) begin
                    state_nx = FLASH_DARK;
                    cnt_nx   = '0;
                end else if (tick) begin
                    if (cnt == LAST) begin
                        state_nx = (state == FLASH_FIRST) ? FLASH_SECOND : FLASH_FIRST;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: begin
                state_nx = FLASH_DARK;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        flash1 = (state == FLASH_FIRST);
        flash2 = (state == FLASH_SECOND);
    end

    assert_dark_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!flash1 && !flash2));
    assert_start_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash1 && !flash2 && active) |=> flash1);
    assert_freeze_without_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (flash1 && active && !tick) |=> flash1);
    assert_complementary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (flash1 != flash2));

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
    import play_status_pkg::*;
(
    input  status_sig_t sig,
    input  logic [1:0]  map_sel,
    output logic        out1,
    output logic        out2,
    output logic        out3
);

    always_comb begin
        unique case (pin_map_e'(map_sel))
            MAP_F2_F1_BUSY:   begin out1 = sig.flash2; out2 = sig.flash1; out3 = sig.busy;  end
            MAP_STOP_F1_F2:   begin out1 = sig.stop;   out2 = sig.flash1; out3 = sig.flash2; end
            MAP_F1_BUSY_STOP: begin out1 = sig.flash1; out2 = sig.busy;   out3 = sig.stop;  end
            MAP_F1_BUSY_NBSY: begin out1 = sig.flash1; out2 = sig.busy;   out3 = !sig.busy; end
            default:          begin out1 = 1'b0;       out2 = 1'b0;       out3 = 1'b0;      end
        endcase
    end

endmodule

// File: rtl/play_status_pins.sv
module play_status_pins
    import play_status_pkg::*;
#(
    parameter int STOP_TICKS = 384,
    parameter int HALF_TICKS = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_in,
    input  logic       group_end,
    input  logic       tick,
    input  logic [1:0] map_sel,
    input  logic       stop_en,
    output logic       out1,
    output logic       out2,
    output logic       out3
);

    logic        busy_q;
    logic        busy_rise;
    status_sig_t sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_in;
    end

    assign busy_rise = busy_in && !busy_q;
    assign sig.busy  = busy_q;

    stop_pulse_seq #(.STOP_TICKS(STOP_TICKS)) u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .group_end (group_end),
        .stop_en   (stop_en),
        .restart   (busy_rise),
        .tick      (tick),
        .stop_o    (sig.stop)
    );

    flash_seq #(.HALF_TICKS(HALF_TICKS)) u_flash (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (busy_in),
        .tick   (tick),
        .flash1 (sig.flash1),
        .flash2 (sig.flash2)
    );

    status_pin_mux u_mux (
        .sig     (sig),
        .map_sel (map_sel),
        .out1    (out1),
        .out2    (out2),
        .out3    (out3)
    );

    assert_busy_on_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_in) && map_sel == 2'd3) |=> (map_sel != 2'd3 || out2));
    assert_inverse_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (map_sel == 2'd3) |-> (out3 != out2));

endmodule

// File: tb/play_status_pins_tb.sv
module play_status_pins_tb;

    localparam int STOP_T = 6;
    localparam int HALF_T = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       busy_in = 1'b0, group_end = 1'b0, tick = 1'b0, stop_en = 1'b0;
    logic [1:0] map_sel = 2'd3;
    logic       out1, out2, out3;

    typedef struct {
        int         due;
        logic [2:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;

    play_status_pins #(.STOP_TICKS(STOP_T), .HALF_TICKS(HALF_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .group_end(group_end),
        .tick(tick), .map_sel(map_sel), .stop_en(stop_en),
        .out1(out1), .out2(out2), .out3(out3)
    );

    task automatic apply(input logic [1:0] s, input logic b, g, e, t);
        @(posedge clk);
        #4;
        map_sel = s; busy_in = b; group_end = g; stop_en = e; tick = t;
    endtask

    task automatic want(input logic [2:0] e, input string tag);
        sb_item_t it;
        it.due = cyc + 1;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: pops expected pin values {out1,out2,out3} as each cycle settles
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if ({out1, out2, out3} !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %b expected %b (cycle %0d)",
                             it.tag, {out1, out2, out3}, it.exp, cyc);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lt;
        int st;
        logic l1;
        // R1: reset state, map code 3 shows inverse busy high
        apply(2'd3, 0, 0, 0, 0); want(3'b001, "R1 reset");
        apply(2'd3, 0, 0, 0, 0); want(3'b001, "R1 reset");
        @(posedge clk); #4; rst_n = 1'b1;

        // R3/R7/R13: flashing under map code 0 {flash2, flash1, busy}
        lt = 0;
        apply(2'd0, 1, 0, 0, 1); want(3'b011, "R3 R7 first phase");
        for (int i = 0; i < 3 * HALF_T; i++) begin
            logic tk;
            tk = (i % 4 != 3);
            apply(2'd0, 1, 0, 0, tk);
            if (tk) lt++;
            l1 = ((lt / HALF_T) % 2 == 0);
            want({~l1, l1, 1'b1}, tk ? "R7 alternation" : "R13 flash hold");
        end
        apply(2'd0, 0, 0, 0, 1); want(3'b000, "R8 dark when idle");
        apply(2'd0, 0, 0, 0, 1); want(3'b000, "R2 R8 idle");
        // R8: new busy period starts from a clean phase
        apply(2'd0, 1, 0, 0, 1); want(3'b011, "R8 fresh phase");
        for (int i = 0; i < HALF_T - 1; i++) begin
            apply(2'd0, 1, 0, 0, 1); want(3'b011, "R8 full first phase");
        end
        apply(2'd0, 1, 0, 0, 1); want(3'b101, "R8 swap after full phase");
        apply(2'd0, 0, 0, 0, 1); want(3'b000, "R8 idle");

        // R5/R9/R13: stop pulse width under map code 2 {flash1, busy, stop}
        apply(2'd2, 0, 1, 1, 1); want(3'b001, "R5 R9 pulse start");
        st = 0;
        for (int i = 0; i < STOP_T + 1; i++) begin
            logic tk;
            tk = (i != 2);
            apply(2'd2, 0, 0, 0, tk);
            if (tk) st++;
            want({2'b00, st < STOP_T}, tk ? "R9 pulse width" : "R13 stop hold");
        end
        apply(2'd2, 0, 0, 0, 1); want(3'b000, "R9 after pulse");

        // R10: disabled stop
        apply(2'd2, 0, 1, 0, 1); want(3'b000, "R10 stop disabled");
        apply(2'd2, 0, 0, 0, 1); want(3'b000, "R10 stop disabled");

        // R12: restart of the width
        apply(2'd2, 0, 1, 1, 1); want(3'b001, "R12 pulse start");
        for (int i = 0; i < 3; i++) begin
            apply(2'd2, 0, 0, 0, 1); want(3'b001, "R12 before restart");
        end
        apply(2'd2, 0, 1, 1, 1); want(3'b001, "R12 restart");
        st = 0;
        for (int i = 0; i < STOP_T; i++) begin
            apply(2'd2, 0, 0, 0, 1);
            st++;
            want({2'b00, st < STOP_T}, "R12 full width after restart");
        end

        // R11: new trigger aborts pulse
        apply(2'd2, 0, 1, 1, 1); want(3'b001, "R11 pulse start");
        apply(2'd2, 0, 0, 0, 1); want(3'b001, "R11 pulse running");
        apply(2'd2, 1, 0, 0, 1); want(3'b110, "R11 abort on trigger");
        apply(2'd2, 1, 0, 0, 1); want(3'b110, "R11 stays ended");
        apply(2'd2, 0, 0, 0, 1); want(3'b000, "R11 idle");

        // R4: map code 1 {stop, flash1, flash2}
        apply(2'd1, 0, 1, 1, 1); want(3'b100, "R4 stop on pin 1");
        apply(2'd1, 1, 0, 0, 1); want(3'b010, "R4 R11 flash on pin 2");
        apply(2'd1, 0, 0, 0, 1); want(3'b000, "R4 idle");

        // R6/R2: map code 3 {flash1, busy, ~busy}, busy without ticks
        apply(2'd3, 1, 0, 0, 0); want(3'b110, "R6 R2 busy without tick");
        apply(2'd3, 1, 0, 0, 0); want(3'b110, "R6 busy held");
        apply(2'd3, 0, 0, 0, 0); want(3'b001, "R6 R2 busy drop");

        repeat (3) @(posedge clk);
        #6;
        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule